// File: doc/BRIEF.md
# Sequential Single-MAC FIR Filter

The block is a 16-tap finite impulse response filter for signed 16-bit fixed-point samples in Q4.12 format. It has a single multiplier-accumulator. Over sixteen consecutive clock cycles, that one unit steps through every tap, so the design needs no array of parallel multipliers. A small state machine controls the sequence. It clears the accumulator, runs the taps, rounds and saturates the sum, and then shifts the history of past samples.

Samples enter through a request/acknowledge handshake, and each filtered result leaves through a matching handshake. The block handles one sample at a time. While a result is being computed or is waiting to be taken, the block refuses new input. The coefficient table is a parameter with a default set. Its entries cannot be changed at run time.

Top module: `fir_mac16`

## Requirements
- R1: During and after reset, `in_ack` is 1, `out_req` is 0 and `out_data` is 0. The sample history is all zeros, so the first result depends only on the first sample.
- R2: A sample is taken at a rising clock edge where `in_req` and `in_ack` are both 1. `in_ack` is 1 exactly when no computation is running and no result is pending.
- R3: `out_req` goes high 17 clock edges after the edge at which the sample was taken.
- R4: While `out_req` is 1 and `out_ack` is 0, `out_req` stays 1 and `out_data` stays unchanged. After an edge with `out_req` and `out_ack` both 1, `out_req` is 0.
- R5: `in_ack` is 0 from the edge that takes a sample until the result has been acknowledged. Data presented on `in_req` during that window is not taken and does not reach the sample history.
- R6: Let x be the new sample, h[k] the Q4.12 coefficient at index k, and s[j] for j = 1..15 the stored history. The result is x·h[15] + Σ s[j]·h[15−j]. The default h[0..15] are the values 1.1, 1.5, 1.0, 1.0, 1.7, 1.8, 1.2, 1.0, 1.6, 1.0, 1.5, 1.1, 1.9, 1.3, 1.4 and 1.7, each rounded to the nearest multiple of 1/4096. Their codes are 4506, 6144, 4096, 4096, 6963, 7373, 4915, 4096, 6554, 4096, 6144, 4506, 7782, 5325, 5734 and 6963.
- R7: When a result is produced, s[15..2] take the old s[14..1] and s[1] takes the new sample.
- R8: The full-precision sum has 24 fractional bits. It is rounded by adding 2^11 and then flooring the division by 2^12, so an exact half rounds toward positive infinity (+1.5 gives 2, −1.5 gives −1).
- R9: A rounded value above 32767 gives `out_data` = 16'h7FFF.
- R10: A rounded value below −32768 gives `out_data` = 16'h8000.
- R11: The accumulator has at least 36 bits (40 by default). Partial sums far outside the 16-bit output range still give the exact rounded and saturated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_req | input | 1 | Input sample offered |
| in_ack | output | 1 | Block ready to take a sample this edge |
| in_data | input | 16 | Input sample, signed Q4.12 |
| out_req | output | 1 | Result valid, held until acknowledged |
| out_ack | input | 1 | Result taken at this edge |
| out_data | output | 16 | Filtered result, signed Q4.12 |

## Verification
Timing is counted from the edge that takes a sample. `in_ack` falls after that edge, and `out_req` with its data is due exactly 17 edges later. The result then stays unchanged until the edge that acknowledges it, and `in_ack` returns high after that edge. The bench keeps a behavioural model that counts the same edges and holds its own copy of the history. It compares `in_ack`, `out_req` and `out_data` with this model on every falling edge, half a cycle away from any update. Directed cases add hand-computed values for the first result after reset, for history shifting, for exact-half rounding, for both saturation limits and for input offered while the block is busy.

// File: rtl/fir_mac16.sv
module fir_mac16 #(
  parameter int DW   = 16,
  parameter int FRAC = 12,
  parameter int NTAP = 16,
  parameter int AW   = 40,
  parameter logic [NTAP*DW-1:0] COEFS = {
    16'h1B33, 16'h1666, 16'h14CD, 16'h1E66, 16'h119A, 16'h1800, 16'h1000, 16'h199A,
    16'h1000, 16'h1333, 16'h1CCD, 16'h1B33, 16'h1000, 16'h1000, 16'h1800, 16'h119A}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_req,
  output logic                 in_ack,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_req,
  input  logic                 out_ack,
  output logic signed [DW-1:0] out_data
);
  localparam int CW  = $clog2(NTAP);
  localparam int PW  = 2 * DW;
  localparam int LAT = NTAP + 1;
  localparam int SW  = $clog2(LAT + 2);
  localparam logic [CW-1:0] LAST = CW'(NTAP - 1);
  localparam logic signed [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [AW-1:0] HALF = {{(AW-1){1'b0}}, 1'b1} << (FRAC - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE, S_HOLD} state_t;

  state_t               st;
  logic [CW-1:0]        idx;
  logic [CW-1:0]        cidx;
  logic signed [DW-1:0] taps [NTAP];
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] op_s, op_c;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] rnd, shf;
  logic                 ovf;
  logic                 take;

  assign in_ack  = (st == S_IDLE);
  assign out_req = (st == S_HOLD);
  assign take    = in_req && in_ack;

  assign cidx = LAST - idx;
  assign op_s = taps[idx];
  assign op_c = COEFS[cidx*DW +: DW];
  assign prod = op_s * op_c;

  assign rnd = acc + HALF;
  assign shf = rnd >>> FRAC;
  assign ovf = !((&shf[AW-1:DW-1]) || !(|shf[AW-1:DW-1]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      acc      <= '0;
      out_data <= '0;
      for (int j = 0; j < NTAP; j++) taps[j] <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_req) begin
          taps[0] <= in_data;
          acc     <= '0;
          idx     <= '0;
          st      <= S_RUN;
        end
        S_RUN: begin
          acc <= acc + AW'(prod);
          idx <= idx + 1'b1;
          if (idx == LAST) st <= S_DONE;
        end
        S_DONE: begin
          out_data <= ovf ? (shf[AW-1] ? NEG_MAX : POS_MAX) : shf[DW-1:0];
          for (int j = NTAP - 1; j > 0; j--) taps[j] <= taps[j-1];
          st <= S_HOLD;
        end
        default: if (out_ack) st <= S_IDLE;
      endcase
    end
  end

  logic [SW-1:0] since_take;
  always_ff @(posedge clk) begin
    if (!rst_n) since_take <= '0;
    else if (take) since_take <= SW'(1);
    else if (since_take != '0 && since_take != SW'(LAT + 1)) since_take <= since_take + 1'b1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> since_take == SW'(LAT + 1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> (out_req && $stable(out_data)));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && out_ack) |=> !out_req);

  // R5
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> !in_ack);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ack);
endmodule

// File: tb/fir_mac16_tb.sv
module fir_mac16_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_req = 1'b0;
  logic out_ack = 1'b0;
  logic signed [15:0] in_data = '0;
  logic in_ack, out_req;
  logic signed [15:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  string cur_tag = "R6";

  always #4 clk = ~clk;

  fir_mac16 u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
  );

  real cr [16] = '{1.1, 1.5, 1.0, 1.0, 1.7, 1.8, 1.2, 1.0, 1.6, 1.0, 1.5, 1.1, 1.9, 1.3, 1.4, 1.7};
  longint cf [16];
  longint hist [16];
  longint m_x, m_pend, m_out;
  int m_cnt = 0;
  bit m_oreq = 1'b0;

  function automatic longint model_result(longint x);
    longint s = x * cf[15];
    for (int j = 1; j < 16; j++) s += hist[j] * cf[15-j];
    s = (s + 2048) >>> 12;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_oreq = 1'b0; m_out = 0;
      for (int j = 0; j < 16; j++) hist[j] = 0;
    end else if (m_oreq) begin
      if (out_ack) m_oreq = 1'b0;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_oreq = 1'b1;
        m_out = m_pend;
        for (int j = 15; j > 1; j--) hist[j] = hist[j-1];
        hist[1] = m_x;
      end
    end else if (in_req) begin
      m_x = longint'(in_data);
      m_pend = model_result(m_x);
      m_cnt = 17;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      chk("R2/R5 in_ack", longint'(in_ack), longint'(!m_oreq && m_cnt == 0));
      chk("R3/R4 out_req", longint'(out_req), longint'(m_oreq));
      if (m_oreq) chk({cur_tag, " out_data"}, longint'(out_data), m_out);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic send(input logic signed [15:0] x);
    @(negedge clk); in_req = 1'b1; in_data = x;
    while (!in_ack) @(negedge clk);
    @(negedge clk); in_req = 1'b0;
  endtask

  task automatic recv(input int stall, output logic signed [15:0] y);
    while (!out_req) @(negedge clk);
    repeat (stall) @(negedge clk);
    y = out_data; out_ack = 1'b1;
    @(negedge clk); out_ack = 1'b0;
  endtask

  task automatic xfer(input logic signed [15:0] x, input int stall, output logic signed [15:0] y);
    send(x);
    recv(stall, y);
  endtask

  task automatic flush();
    logic signed [15:0] y;
    for (int k = 0; k < 15; k++) xfer(16'sd0, 0, y);
  endtask

  initial begin
    logic signed [15:0] y;
    for (int k = 0; k < 16; k++) cf[k] = longint'(cr[k] * 4096.0);

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 in_ack", longint'(in_ack), 1);
    chk("R1 out_req", longint'(out_req), 0);
    chk("R1 out_data", longint'(out_data), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 R6: empty history, 1.0 gives the last coefficient
    cur_tag = "R6";
    xfer(16'sh1000, 2, y);
    chk("R1/R6 first result", longint'(y), 6963);
    // R7: the sample moves one place per result
    cur_tag = "R7";
    xfer(16'sd0, 0, y);
    chk("R7 shift to s1", longint'(y), 5734);
    xfer(16'sd0, 3, y);
    chk("R7 shift to s2", longint'(y), 5325);

    // R5: data offered while busy is not taken
    cur_tag = "R5";
    flush();
    send(16'sh1000);
    @(negedge clk); in_req = 1'b1; in_data = 16'sh7FFF;
    while (!out_req) @(negedge clk);
    in_req = 1'b0;
    recv(1, y);
    chk("R5 result unaffected", longint'(y), 6963);
    xfer(16'sd0, 0, y);
    chk("R5 history holds 1.0 only", longint'(y), 5734);

    // R8: exact halves at s14 with coefficient 1.5
    cur_tag = "R8";
    flush();
    xfer(16'sd1, 0, y);
    chk("R8 1.7 lsb rounds to 2", longint'(y), 2);
    for (int k = 0; k < 14; k++) xfer(16'sd0, 0, y);
    chk("R8 +1.5 rounds to 2", longint'(y), 2);
    flush();
    xfer(-16'sd1, 0, y);
    chk("R8 -1.7 lsb rounds to -2", longint'(y), -2);
    for (int k = 0; k < 14; k++) xfer(16'sd0, 0, y);
    chk("R8 -1.5 rounds to -1", longint'(y), -1);

    // R9 R10: saturation
    cur_tag = "R9";
    flush();
    for (int k = 0; k < 16; k++) begin
      xfer(16'sh7FFF, k % 3, y);
      chk("R9 positive clamp", longint'(y), 32767);
    end
    cur_tag = "R10";
    flush();
    for (int k = 0; k < 16; k++) begin
      xfer(-16'sh8000, 0, y);
      chk("R10 negative clamp", longint'(y), -32768);
    end

    // R11: alternating full-scale signs, large partial sums
    cur_tag = "R11";
    for (int k = 0; k < 40; k++) xfer((k % 2) ? -16'sh8000 : 16'sh7FFF, 0, y);

    // R6: random samples and stalls, compared by the model every cycle
    cur_tag = "R6";
    for (int k = 0; k < 200; k++) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      xfer(16'($urandom_range(0, 65535)), int'($urandom_range(0, 4)), y);
    end

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule